// File: doc/BRIEF.md
# Pin-Change Interrupt Detector

This block watches a group of input pins and raises one shared interrupt flag whenever any selected pin changes level, rising or falling alike. A mask register picks which pins take part. Each pin passes through a transparent latch and a synchronizing register. Each synchronized value is compared with the value it held one cycle before, and the masked differences are registered. Any surviving difference forms a one-cycle set pulse that makes the flag sticky.

The flag stays up until software writes a one to clear it or the interrupt controller acknowledges it. The interrupt request is the flag gated by an enable input. The pins are sampled even when the chip itself drives them, so writing to a pin can raise a software interrupt. A separate combinational wake signal shows a masked pin that differs from its synchronized copy with no clock edge needed. This lets it request wake-up while the core clock is stopped.

Top module: `pcx_detect`

## Requirements
- R1: After a synchronous reset, flag_o and irq_o are 0 and the mask is all zeros, so no pin can set the flag until the mask is written.
- R2: A level change in either direction on a pin whose mask bit is 1 sets flag_o. If the pin changes after clock edge k, flag_o is still 0 after edge k+2 and is 1 after edge k+3.
- R3: A change on a pin whose mask bit is 0 never sets flag_o.
- R4: Once set, flag_o stays at 1 until flag_clr_i or int_ack_i is 1 at a rising edge. It is 0 after that edge unless a set pulse occurs in the same cycle.
- R5: If a set pulse and a clear (flag_clr_i or int_ack_i) occur in the same cycle, flag_o is 1 after the edge.
- R6: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1.
- R7: The mask loads from mask_wdata_i at an edge where mask_we_i is 1, with bit n selecting pin n. After a mask bit is cleared at edge m, a change on that pin driven after edge m sets no flag.
- R8: wake_o is 1, combinationally and with no clock edge, whenever some masked pin differs from its last synchronized value.
- R9: Pins that hold a nonzero level through reset and stay steady afterwards set no flag after reset is released.
- R10: Changes on several masked pins in the same cycle set the single flag once. Further changes while the flag is 1 leave it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Raw pin levels |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NPINS | New mask value, bit n for pin n |
| flag_clr_i | input | 1 | Write-one clear of the flag |
| int_ack_i | input | 1 | Interrupt acknowledge, also clears the flag |
| irq_en_i | input | 1 | Pin-change interrupt enable |
| flag_o | output | 1 | Sticky pin-change flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The checker watches several rules on every cycle. A set pulse always leaves the flag high on the next edge, even when a clear arrives with it. A clear with no set pulse always drops the flag. No registered change bit survives for a pin whose mask was zero. The request never runs ahead of the flag or the enable. A mask write lands on the next edge, and the wake line stays low while the mask is empty. Only the bench's scenarios can show the exact three-edge latency from a pin edge and the absence of a flag after reset with pins held high. They also cover a mask cleared in the middle of toggling and the asynchronous rise of the wake line between clock edges.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int unsigned PCX_PINS_DFLT = 8;

    // Control for the sticky flag: a set request and a clear request.
    typedef struct packed {
        logic set;
        logic clr;
    } pcx_flag_ctl_t;

    // Next flag value: set has priority over clear.
    function automatic logic pcx_next_flag(input pcx_flag_ctl_t ctl, input logic cur);
        return ctl.set | (cur & ~ctl.clr);
    endfunction

endpackage

// File: rtl/pcx_pin_sync.sv
module pcx_pin_sync #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] diff_o
);

    logic [NPINS-1:0] lat;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    // One transparent latch per pin: open while the clock is low.
    for (genvar g = 0; g < NPINS; g++) begin : g_lat
        always_latch begin
            if (!clk_i) begin
                lat[g] <= pin_i[g];
            end
        end
    end

    // During reset both stages follow the pins so no false change appears.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= lat;
            prev_q <= lat;
        end else begin
            sync_q <= lat;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign diff_o = sync_q ^ prev_q;

endmodule

// File: rtl/pcx_change_reg.sv
module pcx_change_reg #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] diff_i,
    input  logic [NPINS-1:0] mask_i,
    output logic [NPINS-1:0] chg_o,
    output logic             set_o
);

    logic [NPINS-1:0] chg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chg_q <= '0;
        end else begin
            chg_q <= diff_i & mask_i;
        end
    end

    assign chg_o = chg_q;
    assign set_o = |chg_q;

endmodule

// File: rtl/pcx_flag.sv
module pcx_flag
    import pcx_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  pcx_flag_ctl_t ctl_i,
    output logic          flag_o
);

    logic flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= pcx_next_flag(ctl_i, flag_q);
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pcx_detect.sv
module pcx_detect
    import pcx_pkg::*;
#(
    parameter int unsigned NPINS = PCX_PINS_DFLT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] pin_i,
    input  logic             mask_we_i,
    input  logic [NPINS-1:0] mask_wdata_i,
    input  logic             flag_clr_i,
    input  logic             int_ack_i,
    input  logic             irq_en_i,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);

    localparam int unsigned MASK_W = NPINS;

    logic [MASK_W-1:0] mask_q;
    logic [NPINS-1:0]  sync_v;
    logic [NPINS-1:0]  diff_v;
    logic [NPINS-1:0]  chg_q;
    logic              set_pulse;
    pcx_flag_ctl_t     fctl;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    pcx_pin_sync #(.NPINS(NPINS)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (pin_i),
        .sync_o (sync_v),
        .diff_o (diff_v)
    );

    pcx_change_reg #(.NPINS(NPINS)) u_chg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .diff_i (diff_v),
        .mask_i (mask_q),
        .chg_o  (chg_q),
        .set_o  (set_pulse)
    );

    always_comb begin
        fctl.set = set_pulse;
        fctl.clr = flag_clr_i | int_ack_i;
    end

    pcx_flag u_flag (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctl_i  (fctl),
        .flag_o (flag_o)
    );

    assign irq_o  = flag_o & irq_en_i;
    // Clock-free wake request straight from the pins.
    assign wake_o = |((pin_i ^ sync_v) & mask_q);

endmodule

// File: rtl/pcx_detect_chk.sv
module pcx_detect_chk #(
    parameter int unsigned NPINS = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             mask_we_i,
    input logic [NPINS-1:0] mask_wdata_i,
    input logic             flag_clr_i,
    input logic             int_ack_i,
    input logic             irq_en_i,
    input logic             flag_o,
    input logic             irq_o,
    input logic             wake_o,
    input logic             set_pulse,
    input logic [NPINS-1:0] chg_q,
    input logic [NPINS-1:0] mask_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (!flag_o && mask_q == '0));

    // R2
    flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(flag_o) |-> $past(set_pulse));

    // R3
    masked_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_we_i |=> ((chg_q & ~$past(mask_q)) == '0));

    // R4
    clear_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((flag_clr_i || int_ack_i) && !set_pulse) |=> !flag_o);

    // R4
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !flag_clr_i && !int_ack_i) |=> flag_o);

    // R5
    set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        set_pulse |=> flag_o);

    // R6
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flag_o && irq_en_i));

    // R6
    irq_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_en_i |-> !irq_o);

    // R7
    mask_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mask_we_i |=> (mask_q == $past(mask_wdata_i)));

    // R8
    wake_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_q == '0) |-> !wake_o);

endmodule

bind pcx_detect pcx_detect_chk #(.NPINS(NPINS)) u_pcx_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .flag_clr_i   (flag_clr_i),
    .int_ack_i    (int_ack_i),
    .irq_en_i     (irq_en_i),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o),
    .set_pulse    (set_pulse),
    .chg_q        (chg_q),
    .mask_q       (mask_q)
);

// File: tb/pcx_detect_bench.sv
`timescale 1ns/1ps
module pcx_detect_bench;

    localparam int unsigned NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin;
    logic          mask_we;
    logic [NP-1:0] mask_wdata;
    logic          flag_clr;
    logic          int_ack;
    logic          irq_en;
    logic          flag_o;
    logic          irq_o;
    logic          wake_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pcx_detect #(.NPINS(NP)) u_pcx_detect (
        .clk_i        (clk),
        .rst_i        (rst),
        .pin_i        (pin),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .flag_clr_i   (flag_clr),
        .int_ack_i    (int_ack),
        .irq_en_i     (irq_en),
        .flag_o       (flag_o),
        .irq_o        (irq_o),
        .wake_o       (wake_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_mask(input logic [NP-1:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic pulse_clr(input bit use_ack);
        if (use_ack) int_ack = 1'b1; else flag_clr = 1'b1;
        tick();
        int_ack = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic do_reset(input logic [NP-1:0] p);
        rst = 1'b1; pin = p;
        tick(3);
        rst = 1'b0;
    endtask

    // Expected next flag from the requirements (set wins over clear).
    function automatic logic exp_flag(input logic setp, input logic clr, input logic cur);
        return setp | (cur & ~clr);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] h0, h1, mm, cm, np;
        logic fm, cl, ak;
        void'($urandom(32'h1f2e3d4c));
        mask_we = 0; mask_wdata = 0; flag_clr = 0; int_ack = 0; irq_en = 0; pin = 0;

        // R1: reset state, empty mask blocks every pin
        do_reset('0);
        check("R1 flag after reset", flag_o, 0);
        check("R1 irq after reset", irq_o, 0);
        pin = 8'hFF; tick(5);
        check("R1 empty mask blocks toggles", flag_o, 0);

        // R9: pins held high through reset
        do_reset(8'hA5);
        write_mask(8'hFF);
        tick(5);
        check("R9 no flag from steady pins", flag_o, 0);

        // R2: rising toggle, exact latency
        do_reset('0);
        write_mask(8'h01);
        pin = 8'h01;
        tick(2);
        check("R2 flag not before third edge", flag_o, 0);
        tick();
        check("R2 flag at third edge rising", flag_o, 1);
        pulse_clr(0);
        pin = 8'h00;
        tick(2);
        check("R2 falling not early", flag_o, 0);
        tick();
        check("R2 flag at third edge falling", flag_o, 1);

        // R4: sticky, then write-one clear and acknowledge
        tick(10);
        check("R4 flag holds", flag_o, 1);
        pulse_clr(0);
        check("R4 write-one clear", flag_o, 0);
        pin = 8'h01; tick(4);
        check("R4 flag set again", flag_o, 1);
        pulse_clr(1);
        check("R4 acknowledge clears", flag_o, 0);

        // R3: unmasked pin
        pin = 8'h81; tick(6);
        check("R3 unmasked pin ignored", flag_o, 0);

        // R5: set and clear in the same cycle
        pin = 8'h80; tick(4);
        check("R5 setup flag", flag_o, 1);
        pin = 8'h81;
        tick(2);
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        check("R5 set wins over clear", flag_o, 1);
        pulse_clr(0);
        check("R5 later clear works", flag_o, 0);

        // R6: enable gating
        pin = 8'h80; tick(4);
        irq_en = 0; #1;
        check("R6 irq off when disabled", irq_o, 0);
        irq_en = 1; #1;
        check("R6 irq on when enabled", irq_o, 1);
        pulse_clr(0);
        check("R6 irq follows cleared flag", irq_o, 0);

        // R8: wake between edges, no clock edge in between
        pin = 8'h81; #1;
        check("R8 wake asynchronous", wake_o, 1);
        tick(4);
        check("R8 wake drops once synced", wake_o, 0);
        pulse_clr(0);

        // R7: mask cleared, then toggling pin gives nothing
        write_mask(8'h00);
        pin = 8'h80; tick();
        pin = 8'h81; tick();
        pin = 8'h80; tick(5);
        check("R7 cleared mask blocks pin", flag_o, 0);
        #1;
        check("R8 wake quiet with empty mask", wake_o, 0);

        // R10: several pins together, and toggles while set
        write_mask(8'hF0);
        pin = 8'hF0; tick(4);
        check("R10 several pins set flag", flag_o, 1);
        pin = 8'h00; tick(); pin = 8'h30; tick(5);
        check("R10 flag stays while toggling", flag_o, 1);
        pulse_clr(1);
        check("R10 cleared after toggles", flag_o, 0);

        // Random phase against a timing model (R2 R3 R4 R5 R6 R7 R8)
        pin = 8'h3C;
        do_reset(8'h3C);
        h0 = 8'h3C; h1 = 8'h3C; mm = '0; cm = '0; fm = 1'b0;
        for (int it = 0; it < 600; it++) begin
            check("R4 random flag", flag_o, fm);
            check("R6 random irq", irq_o, fm & irq_en);
            np = ($urandom_range(0, 2) == 0) ? pin ^ NP'($urandom) : pin;
            pin = np;
            mask_we = ($urandom_range(0, 9) == 0);
            mask_wdata = NP'($urandom);
            cl = ($urandom_range(0, 5) == 0);
            ak = ($urandom_range(0, 7) == 0);
            flag_clr = cl; int_ack = ak;
            irq_en = $urandom_range(0, 1);
            #1;
            check("R8 random wake", wake_o, |((np ^ h0) & mm));
            @(posedge clk);
            fm = exp_flag(|cm, cl | ak, fm);
            cm = (h0 ^ h1) & mm;
            h1 = h0; h0 = np;
            if (mask_we) mm = mask_wdata;
            #1;
        end
        mask_we = 0; flag_clr = 0; int_ack = 0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule